// File: doc/BRIEF.md
# Printer Port Register Block with Emulated Handshake

This block is the host-facing register file of a standard byte-wide printer port. A host reaches it through a simple single-cycle read/write bus with a 3-bit offset. Behind the bus sit four byte registers: an outgoing data latch, an incoming data latch, a status byte and a control byte.

No printer pins are watched. Instead, the block itself plays the printer's side of the handshake. Control writes and status reads move the busy, ack and interrupt bits through a fixed sequence. When software pulses strobe, the outgoing byte is handed to a byte-output port as a one-cycle valid pulse. The incoming latch is filled from an external byte bus whenever a load strobe is raised. A level interrupt line reports a pending-interrupt flag.

Read data is combinational from the current offset and the register contents. Every side effect of an access (register updates, flag changes, the output pulse) becomes visible after the clock edge that ends the access.

Top module: `lpt_regblock`

## Requirements
- R1: Offset 0 selects data, offset 1 status and offset 2 control. A read at offsets 3 to 7 returns 0xFF, and a write there changes no register, no output and no flag.
- R2: A write to control stores the written byte with bits 7 and 6 forced to 1, and a read at offset 2 returns that stored value.
- R3: A control write whose bit 2 (init) is 0 sets the status byte to 0xD8.
- R4: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7 (busy). If the strobe bit stored before that write was 0, the data latch appears on byte_out with byte_valid high for exactly the one cycle after the write edge. Otherwise byte_valid stays low.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the pending-interrupt flag when the previously stored control bit 4 (interrupt enable) is 1. irq equals the flag and goes high from the cycle after that write.
- R6: A status read returns the status byte held before the access and clears the pending flag, so irq is low from the next cycle. If status bit 7 is 0 and the stored strobe is 0, the read then clears status bit 6 (ack) when it was 1, and otherwise sets both bit 6 and bit 7.
- R7: A data read returns the incoming latch when control bit 5 (direction) is 1 and the outgoing latch when it is 0. A data write updates the outgoing latch.
- R8: While ext_load is high at a clock edge, the incoming latch takes ext_din.
- R9: After reset both data latches hold 0xFF, status is 0xD9, control is 0xCC, irq is 0 and byte_valid is 0.
- R10: A write at offset 1 has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| ext_din | input | 8 | Incoming byte bus |
| ext_load | input | 1 | Load incoming byte into the input latch |
| byte_out | output | 8 | Emitted output byte |
| byte_valid | output | 1 | One-cycle pulse marking byte_out |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The assertions assume the bus is quiet while reset is held, so that the first $past after release sees no access. They also assume bus_rdata is only meaningful while a read is selected, which is why the read checks are gated on bus_sel with bus_wr low. The stimulus drives each access for exactly one cycle, away from the clock edge, and idles the bus during reset. Its control bytes step through the init, select, strobe and interrupt-enable combinations in the orders that exercise each branch of the handshake, including a repeated strobe that must not emit twice.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // register offsets
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    // status bit positions
    localparam int ST_BUSYN = 7;
    localparam int ST_ACK   = 6;

    // control bit positions
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam byte_t DATA_RST  = 8'hFF;
    localparam byte_t STAT_RST  = 8'hD9;
    localparam byte_t CTRL_RST  = 8'hCC;
    localparam byte_t STAT_IDLE = 8'hD8;
    localparam byte_t CTRL_HIGH = 8'hC0;
    localparam byte_t NO_REG    = 8'hFF;

    typedef struct packed {
        byte_t dout;
        byte_t din;
        byte_t stat;
        byte_t ctrl;
        logic  pend;
        logic  vld;
        byte_t bout;
    } lpt_regs_t;
endpackage

// File: rtl/lpt_ctrl_write.sv
module lpt_ctrl_write
    import lpt_pkg::*;
(
    input  byte_t wdata,
    input  logic  old_stb,
    input  logic  old_ien,
    input  byte_t stat_cur,
    output byte_t ctrl_new,
    output byte_t stat_new,
    output logic  emit,
    output logic  pend_set
);
    always_comb begin
        ctrl_new = wdata | CTRL_HIGH;
        stat_new = stat_cur;
        emit     = 1'b0;
        pend_set = 1'b0;
        if (!ctrl_new[CT_INIT]) begin
            stat_new = STAT_IDLE;
        end else if (ctrl_new[CT_SEL]) begin
            if (ctrl_new[CT_STB]) begin
                stat_new[ST_BUSYN] = 1'b0;
                emit = !old_stb;
            end else begin
                pend_set = old_ien;
            end
        end
    end
endmodule

// File: rtl/lpt_stat_step.sv
module lpt_stat_step
    import lpt_pkg::*;
(
    input  byte_t stat_cur,
    input  logic  cur_stb,
    output byte_t stat_next
);
    always_comb begin
        stat_next = stat_cur;
        if (!stat_cur[ST_BUSYN] && !cur_stb) begin
            if (stat_cur[ST_ACK]) begin
                stat_next[ST_ACK] = 1'b0;
            end else begin
                stat_next[ST_ACK]   = 1'b1;
                stat_next[ST_BUSYN] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_read_mux.sv
module lpt_read_mux
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             dout,
    input  byte_t             din,
    input  byte_t             stat,
    input  byte_t             ctrl,
    output byte_t             rdata
);
    always_comb begin
        if (addr == ADDR_W'(OFS_DATA))
            rdata = ctrl[CT_DIR] ? din : dout;
        else if (addr == ADDR_W'(OFS_STAT))
            rdata = stat;
        else if (addr == ADDR_W'(OFS_CTRL))
            rdata = ctrl;
        else
            rdata = NO_REG;
    end
endmodule

// File: rtl/lpt_regblock.sv
module lpt_regblock
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        ext_din,
    input  logic              ext_load,
    output logic [7:0]        byte_out,
    output logic              byte_valid,
    output logic              irq
);
    lpt_regs_t r_d, r_q;

    logic  wr_data_d, wr_ctrl_d, rd_stat_d;
    byte_t ctrl_new, stat_new, stat_after;
    logic  emit, pend_set;

    assign wr_data_d = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_ctrl_d = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign rd_stat_d = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

    lpt_ctrl_write u_cw (
        .wdata    (bus_wdata),
        .old_stb  (r_q.ctrl[CT_STB]),
        .old_ien  (r_q.ctrl[CT_IEN]),
        .stat_cur (r_q.stat),
        .ctrl_new (ctrl_new),
        .stat_new (stat_new),
        .emit     (emit),
        .pend_set (pend_set)
    );

    lpt_stat_step u_ss (
        .stat_cur  (r_q.stat),
        .cur_stb   (r_q.ctrl[CT_STB]),
        .stat_next (stat_after)
    );

    lpt_read_mux #(.ADDR_W(ADDR_W)) u_rm (
        .addr  (bus_addr),
        .dout  (r_q.dout),
        .din   (r_q.din),
        .stat  (r_q.stat),
        .ctrl  (r_q.ctrl),
        .rdata (bus_rdata)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (ext_load)
            r_d.din = ext_din;
        if (wr_data_d)
            r_d.dout = bus_wdata;
        if (wr_ctrl_d) begin
            r_d.ctrl = ctrl_new;
            r_d.stat = stat_new;
            if (emit) begin
                r_d.vld  = 1'b1;
                r_d.bout = r_q.dout;
            end
            if (pend_set)
                r_d.pend = 1'b1;
        end
        if (rd_stat_d) begin
            r_d.pend = 1'b0;
            r_d.stat = stat_after;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.dout <= DATA_RST;
            r_q.din  <= DATA_RST;
            r_q.stat <= STAT_RST;
            r_q.ctrl <= CTRL_RST;
            r_q.pend <= 1'b0;
            r_q.vld  <= 1'b0;
            r_q.bout <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_out   = r_q.bout;
    assign byte_valid = r_q.vld;
    assign irq        = r_q.pend;
endmodule

// File: rtl/lpt_regblock_chk.sv
module lpt_regblock_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              byte_valid,
    input logic              irq,
    input logic [7:0]        stat_q
);
    logic ctl_wr, stat_rd, data_rd;
    assign ctl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
    assign stat_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(1));
    assign data_rd = bus_sel && !bus_wr && (bus_addr > ADDR_W'(2));

    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |-> bus_rdata == 8'hFF); // R1
    AST_CTRL_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(2)) |-> bus_rdata[7:6] == 2'b11); // R2
    AST_INIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !bus_wdata[2]) |=> stat_q == 8'hD8); // R3
    AST_STROBE_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[2] && bus_wdata[3] && bus_wdata[0]) |=> !stat_q[7]); // R4
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R4
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(ctl_wr && bus_wdata[2] && bus_wdata[3] && bus_wdata[0])); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctl_wr && bus_wdata[2] && bus_wdata[3] && !bus_wdata[0])); // R5
    AST_STAT_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !irq); // R6
    AST_STAT_WRITE_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(1)) |=> $stable(stat_q)); // R10
endmodule

bind lpt_regblock lpt_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .byte_valid (byte_valid),
    .irq        (irq),
    .stat_q     (r_q.stat)
);

// File: tb/lpt_regblock_bench.sv
`timescale 1ns/1ps
module lpt_regblock_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] ext_din = '0;
    logic       ext_load = 1'b0;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpt_regblock u_lpt_regblock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_din(ext_din), .ext_load(ext_load), .byte_out(byte_out),
        .byte_valid(byte_valid), .irq(irq)
    );

    // behavioural reference model
    int m_dout, m_din, m_sts, m_ctl, m_bout;
    bit m_irq, m_vld;

    always @(posedge clk) begin
        int v;
        if (!rst_n) begin
            m_dout = 255; m_din = 255; m_sts = 'hD9; m_ctl = 'hCC;
            m_irq = 0; m_vld = 0; m_bout = 0;
        end else begin
            m_vld = 0;
            if (ext_load) m_din = ext_din;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 0) m_dout = bus_wdata;
                if (bus_addr == 2) begin
                    v = bus_wdata + 0;
                    v = v | 'hC0;
                    if ((v & 4) == 0) m_sts = 'hD8;
                    else if ((v & 8) != 0) begin
                        if ((v & 1) != 0) begin
                            m_sts = m_sts & 'h7F;
                            if ((m_ctl & 1) == 0) begin m_vld = 1; m_bout = m_dout; end
                        end else if ((m_ctl & 'h10) != 0) m_irq = 1;
                    end
                    m_ctl = v;
                end
            end
            if (bus_sel && !bus_wr && bus_addr == 1) begin
                m_irq = 0;
                if ((m_sts & 'h80) == 0 && (m_ctl & 1) == 0) begin
                    if ((m_sts & 'h40) != 0) m_sts = m_sts & 'hBF;
                    else m_sts = m_sts | 'hC0;
                end
            end
        end
    end

    function automatic int m_read(input int a);
        if (a == 0) return ((m_ctl & 'h20) != 0) ? m_din : m_dout;
        if (a == 1) return m_sts;
        if (a == 2) return m_ctl;
        return 255;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5/R6 irq vs model", irq, m_irq);
            chk("R4 byte_valid vs model", byte_valid, m_vld);
            if (m_vld) chk("R4 byte_out vs model", byte_out, m_bout);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d); ext_load = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 3'(a); ext_load = 0;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " (model)"}, bus_rdata, m_read(a));
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; ext_load = 0;
    endtask

    task automatic load(input int d);
        @(negedge clk);
        bus_sel = 0; ext_load = 1; ext_din = 8'(d);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        chk("R9 irq after reset", irq, 0);
        chk("R9 byte_valid after reset", byte_valid, 0);
        rd(0, 'hFF, "R9 data reset");
        rd(1, 'hD9, "R9 status reset");
        rd(2, 'hCC, "R9 control reset");
        for (int a = 3; a < 8; a++) rd(a, 'hFF, "R1 unmapped read");
        wr(0, 'h55);
        rd(0, 'h55, "R7 output latch read");
        load('hA3);
        wr(2, 'h2C);
        rd(0, 'hA3, "R8 R7 input latch read");
        rd(2, 'hEC, "R2 control forced bits");
        wr(1, 'h00);
        rd(1, 'hD9, "R10 status write ignored");
        wr(2, 'h00);
        rd(1, 'hD8, "R3 init clears status");
        rd(2, 'hC0, "R2 control zero write");
        wr(0, 'h5A);
        wr(2, 'h1C);
        idle();
        chk("R5 no irq without prior enable", irq, 0);
        wr(2, 'h1C);
        idle();
        chk("R5 irq raised", irq, 1);
        wr(2, 'h1D);
        idle();
        chk("R4 pulse high", byte_valid, 1);
        chk("R4 pulse byte", byte_out, 'h5A);
        idle();
        chk("R4 pulse one cycle", byte_valid, 0);
        wr(2, 'h1D);
        idle();
        chk("R4 no second emit", byte_valid, 0);
        rd(1, 'h58, "R4 busy cleared");
        idle();
        chk("R6 irq cleared by status read", irq, 0);
        wr(2, 'h1C);
        idle();
        chk("R5 irq raised again", irq, 1);
        rd(1, 'h58, "R6 read with ack set");
        rd(1, 'h18, "R6 ack cleared");
        rd(1, 'hD8, "R6 ack and busy set");
        rd(1, 'hD8, "R6 busy blocks sequence");
        wr(5, 'h00); wr(7, 'h00); wr(3, 'h00);
        idle();
        chk("R1 unmapped write no pulse", byte_valid, 0);
        rd(0, 'h5A, "R1 data unchanged");
        rd(1, 'hD8, "R1 status unchanged");
        rd(2, 'hDC, "R1 control unchanged");
        wr(2, 'h3F);
        idle();
        chk("R4 emit on all-ones control", byte_valid, 1);
        rd(2, 'hFF, "R2 control all ones");
        rd(0, 'hA3, "R7 direction read");
        rd(1, 'h58, "R4 busy cleared again");
        idle();
        idle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule